// File: doc/BRIEF.md
# Converter Serial Output Framer

This block is the digital output port of a sampling converter. Each word slot lasts 64 master clock cycles. In every slot it sends one 16-bit two's complement sample on a serial data line. It derives its own serial clock from the master clock by dividing by three. A frame pulse marks the master clock cycles that carry data bits. Inverted copies of the data line and the clock line are driven as well, so that a board can route the port as a differential pair.

Samples enter through a valid/ready stream port that holds one pending word.
- A transfer happens on any master clock edge where `s_valid` and `s_ready` are both high.
- After a transfer, `s_ready` stays low until the pending word is taken.
- The pending word is taken on the edge that ends slot cycle 62, and it goes out in the slot that follows.
- A producer that finds `s_ready` low must keep `s_valid` and `s_data` unchanged.
- If no sample has been accepted when the next slot begins, the previous word is sent again.

Slot cycles are numbered from 0 to 63. Serial clock period k covers slot cycles 3k, 3k+1 and 3k+2, for k from 0 to 20. Cycle 63 is an idle cycle, and it is the cycle in which the next word is placed on the line.

Top module: `conv_serial_framer`

## Requirements
- R1: In each slot the word is sent most significant bit first, with no change to its two's complement value. Bit k (bit 15 is k = 0) is valid at the rising serial clock edge at the start of slot cycle 3k.
- R2: `sclk` is high in slot cycles 0, 3, 6, …, 60 and low in every other cycle. A rising edge therefore follows the one before it after 3 master clocks, except the first rise of a slot, which follows 4 master clocks after the last rise of the previous slot.
- R3: A slot is 64 master clocks long. `fso` is high in slot cycles 0 to 47, which are the 16 periods that carry data, and low in cycles 48 to 63, so `fso` rises once every 64 master clocks.
- R4: `sdo` changes only in a cycle where `sclk` has just fallen, or in slot cycle 63.
- R5: `sdo` is low from slot cycle 46 to slot cycle 62.
- R6: `sdo_n` is always the inverse of `sdo`, and `sclk_n` is always the inverse of `sclk`.
- R7: `s_ready` is high exactly when no word is pending. A transfer on an edge other than the edge ending slot cycle 62 stores the word and drops `s_ready` on the next cycle. The stored word is not changed until that edge.
- R8: The word sent in a slot is chosen on the edge that ends slot cycle 62 of the slot before it. The choice is, in order of priority: the pending word; otherwise a word transferred on that same edge; otherwise the word sent in the slot before.
- R9: While `rst` is high, `sdo`, `sclk` and `fso` are low, `sdo_n` and `sclk_n` are high, and `s_ready` is high. The cycle after `rst` falls is slot cycle 63, and the first slot that follows carries the word 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready (no word pending) |
| s_data | input | WORD_W (16) | Sample word, two's complement |
| sdo | output | 1 | Serial data, MSB first |
| sdo_n | output | 1 | Inverse of sdo |
| sclk | output | 1 | Serial clock, master clock / 3 within a slot |
| sclk_n | output | 1 | Inverse of sclk |
| fso | output | 1 | Frame marker, high during the data periods |

## Verification
The assertions check the following on every cycle:
- each serial clock high is followed by two low cycles;
- the frame pulse rises only right after the idle cycle;
- the data line moves only at a falling serial clock edge or in the idle cycle, and it is low between the last data bit and the idle cycle;
- the pending word and the ready handshake stay consistent.

Some behaviour can only be shown by the bench scenarios. The bench rebuilds each word from the line and compares it with the word the slot should carry. This covers the value sent, its bit order, whether a word is repeated, and whether a pending word wins over a transfer on the load edge. The bench also shows the 4-cycle gap across a slot boundary, the complements, and the zero word after a reset in the middle of a run.

// File: rtl/cvf_pkg.sv
package cvf_pkg;
  typedef struct packed {
    logic sclk;
    logic fso;
    logic shift;
    logic load;
    logic idle;
  } slot_ctl_t;
endpackage

// File: rtl/cvf_timebase.sv
module cvf_timebase
  import cvf_pkg::*;
#(
  parameter int SLOT_CYC = 64,
  parameter int DIV      = 3,
  parameter int WORD_W   = 16
) (
  input  logic      clk,
  input  logic      rst,
  output slot_ctl_t ctl
);
  localparam int NPER = (SLOT_CYC - 1) / DIV;
  localparam int CW   = $clog2(SLOT_CYC);
  localparam int PHW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int PW   = $clog2(NPER + 1);
  localparam logic [CW-1:0]  LAST    = CW'(SLOT_CYC - 1);
  localparam logic [CW-1:0]  PRELAST = CW'(SLOT_CYC - 2);
  localparam logic [PHW-1:0] PH_TOP  = PHW'(DIV - 1);
  localparam logic [PW-1:0]  P_WORD  = PW'(WORD_W);
  localparam logic [PW-1:0]  P_END   = PW'(NPER);

  logic [CW-1:0]  cyc;
  logic [PHW-1:0] phase;
  logic [PW-1:0]  period;

  // The divider restarts at each slot start, since 64 is not a multiple of 3
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc    <= LAST;
      phase  <= '0;
      period <= P_END;
    end else if (cyc == LAST) begin
      cyc    <= '0;
      phase  <= '0;
      period <= '0;
    end else begin
      cyc <= cyc + 1'b1;
      if (phase == PH_TOP) begin
        phase  <= '0;
        period <= period + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.idle  = (cyc == LAST);
    ctl.load  = (cyc == PRELAST);
    ctl.sclk  = (phase == '0) && (period < P_END);
    ctl.fso   = (period < P_WORD);
    ctl.shift = (phase == '0) && (period < P_WORD);
  end

  p_sclk_gap_r2: assert property (@(posedge clk) disable iff (rst)
    ctl.sclk |=> !ctl.sclk ##1 !ctl.sclk);

  p_fso_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl.fso) |-> $past(ctl.idle));
endmodule

// File: rtl/cvf_word_hold.sv
module cvf_word_hold #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic              load,
  output logic [WORD_W-1:0] word_next
);
  logic              full;
  logic [WORD_W-1:0] pend;
  logic [WORD_W-1:0] cur;
  logic              accept;

  assign s_ready = ~full;
  assign accept  = s_valid & ~full;

  // Priority on the load edge: pending word, then a same-edge transfer, then a repeat
  always_comb begin
    if (full)        word_next = pend;
    else if (accept) word_next = s_data;
    else             word_next = cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      pend <= '0;
      cur  <= '0;
    end else if (load) begin
      cur  <= word_next;
      full <= 1'b0;
    end else if (accept) begin
      pend <= s_data;
      full <= 1'b1;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (full && !load) |=> (full && $stable(pend)));

  p_ready_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && !load) |=> !s_ready);
endmodule

// File: rtl/cvf_shifter.sv
module cvf_shifter
  import cvf_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  slot_ctl_t         ctl,
  input  logic [WORD_W-1:0] word_next,
  output logic              sdo
);
  logic [WORD_W-1:0] shreg;

  // The load lands in the idle cycle; each shift happens as sclk falls
  always_ff @(posedge clk) begin
    if (rst)            shreg <= '0;
    else if (ctl.load)  shreg <= word_next;
    else if (ctl.shift) shreg <= {shreg[WORD_W-2:0], 1'b0};
  end

  assign sdo = shreg[WORD_W-1];

  p_sdo_edge_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> ($fell(ctl.sclk) || ctl.idle));

  p_sdo_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctl.fso && !ctl.idle) |-> !sdo);
endmodule

// File: rtl/conv_serial_framer.sv
module conv_serial_framer
  import cvf_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int SLOT_CYC = 64,
  parameter int DIV      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  output logic              sdo,
  output logic              sdo_n,
  output logic              sclk,
  output logic              sclk_n,
  output logic              fso
);
  slot_ctl_t         ctl;
  logic [WORD_W-1:0] word_next;

  cvf_timebase #(.SLOT_CYC(SLOT_CYC), .DIV(DIV), .WORD_W(WORD_W)) u_time (
    .clk(clk), .rst(rst), .ctl(ctl)
  );

  cvf_word_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .load(ctl.load), .word_next(word_next)
  );

  cvf_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .ctl(ctl), .word_next(word_next), .sdo(sdo)
  );

  assign sclk   = ctl.sclk;
  assign fso    = ctl.fso;
  assign sdo_n  = ~sdo;
  assign sclk_n = ~ctl.sclk;
endmodule

// File: tb/conv_serial_framer_test.sv
module conv_serial_framer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic        s_ready, sdo, sdo_n, sclk, sclk_n, fso;

  conv_serial_framer uut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .sdo(sdo), .sdo_n(sdo_n), .sclk(sclk), .sclk_n(sclk_n), .fso(fso)
  );

  always #10ns clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int n;
  bit full_m;
  logic [15:0] pend_m, cur_m;
  logic [15:0] exp_q [0:255];
  int wr, rd, nb, last_rise, last_fso;
  logic [15:0] bits;
  logic prev_sclk, prev_sdo;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int slot_cyc(input int e);
    return (e == 0) ? 63 : (e - 1) % 64;
  endfunction

  task automatic monitor();
    int c;
    bit es, ef;
    c  = slot_cyc(n);
    es = (c < 63) && (c % 3 == 0);
    ef = (c < 48);
    chk(sclk == es, "R2 sclk", sclk, es);
    chk(fso == ef, "R3 fso", fso, ef);
    chk(sdo_n == ~sdo && sclk_n == ~sclk, "R6 complements", {sdo_n, sclk_n}, {~sdo, ~sclk});
    if (c >= 46 && c <= 62) chk(sdo == 1'b0, "R5 quiet line", sdo, 0);
    if (sdo != prev_sdo) chk((prev_sclk && !sclk) || c == 63, "R4 sdo edge", c, 63);
    if (sclk && !prev_sclk) begin
      if (last_rise >= 0) chk(n - last_rise == ((c == 0) ? 4 : 3), "R2 spacing", n - last_rise, (c == 0) ? 4 : 3);
      last_rise = n;
    end
    if (fso && last_fso >= 0 && c == 0) begin
      chk(n - last_fso == 64, "R3 frame spacing", n - last_fso, 64);
    end
    if (fso && c == 0) last_fso = n;
    if (sclk && fso) begin
      bits = {bits[14:0], sdo};
      nb++;
      if (nb == 16) begin
        chk(bits == exp_q[rd % 256], (rd == 0) ? "R9 first word" : "R1/R8 word", bits, exp_q[rd % 256]);
        rd++;
        nb = 0;
      end
    end
    prev_sclk = sclk;
    prev_sdo  = sdo;
  endtask

  task automatic step(input bit v, input logic [15:0] d);
    bit hs;
    s_valid = v;
    s_data  = d;
    chk(s_ready == !full_m, "R7 ready", s_ready, !full_m);
    hs = v && !full_m;
    if ((n + 1) % 64 == 0) begin
      cur_m  = full_m ? pend_m : (hs ? d : cur_m);
      full_m = 0;
      exp_q[wr % 256] = cur_m;
      wr++;
    end else if (hs) begin
      pend_m = d;
      full_m = 1;
    end
    @(negedge clk);
    n++;
    monitor();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    s_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sdo && !sclk && !fso && sdo_n && sclk_n && s_ready, "R9 reset state",
        {sdo, sclk, fso, sdo_n, sclk_n, s_ready}, 6'b000111);
    rst = 1'b0;
    n = 0; full_m = 0; pend_m = '0; cur_m = '0;
    exp_q[0] = '0; wr = 1; rd = 0; nb = 0; bits = '0;
    last_rise = -1; last_fso = -1; prev_sclk = 0; prev_sdo = 0;
    monitor();
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();
    // random traffic
    for (int i = 0; i < 64 * 12; i++) step(($urandom % 4) == 0, 16'($urandom));
    // no traffic: words repeat (R8)
    for (int i = 0; i < 64 * 3; i++) step(1'b0, 16'h0);
    // transfer only on the load edge with nothing pending (R8 same-edge path)
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < 64; i++) begin
        logic [15:0] w;
        w = (f == 0) ? 16'h8000 : (f == 1) ? 16'h7FFF : 16'hFFFF;
        step(slot_cyc(n) == 62, w);
      end
    // continuous valid: back-pressure, pending word wins on the load edge (R7, R8)
    for (int i = 0; i < 64 * 4; i++) step(1'b1, 16'(16'hA500 + i));
    // reset in the middle of a run (R9)
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 64 * 6; i++) step(($urandom % 3) == 0, 16'($urandom));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule